// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit operands and a carry-in in one combinational pass. The operands are cut into four 4-bit slices. Each slice forms per-bit generate and propagate terms, works out its own internal carries in flat sum-of-products form, and reduces itself to one slice propagate and one slice generate. A second lookahead stage takes those four pairs and the carry-in and produces the carry into every slice at once. No carry passes from one slice to the next.

The block also brings out the four slice propagate and generate pairs and one block-wide propagate and generate pair. The block-wide pair lets several of these adders sit under a further lookahead stage to build a wider adder. There is no clock and no state, so the outputs follow the inputs after the logic settles.

Top module: `cla2_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + cin_i`, all taken as unsigned.
- R2: `cout_o` equals bit 16 of `a_i + b_i + cin_i`.
- R3: `blk_p_o` is 1 exactly when every bit position has `a_i` or `b_i` set, that is when `(a_i | b_i)` is all ones.
- R4: `blk_g_o` is 1 exactly when `a_i + b_i` with no carry-in reaches 2^16. It does not depend on `cin_i`.
- R5: `grp_p_o[k]` is 1 exactly when `(a_i | b_i)` is all ones in bits 4k+3 down to 4k. Index 0 is the least significant slice.
- R6: `grp_g_o[k]` is 1 exactly when the 4-bit add of bits 4k+3..4k of `a_i` and `b_i`, with no carry-in, carries out.
- R7: A carry made in the lowest slice, or brought in on `cin_i`, reaches every higher slice and `cout_o` in the same evaluation. For example, `0xFFFF + 0x0000 + 1` gives `sum_o = 0x0000` and `cout_o = 1`.
- R8: With all inputs zero, every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum, modulo 2^16 |
| cout_o | output | 1 | Carry out of bit 15 |
| grp_p_o | output | 4 | Propagate of each 4-bit slice |
| grp_g_o | output | 4 | Generate of each 4-bit slice |
| blk_p_o | output | 1 | Propagate of the whole 16-bit adder |
| blk_g_o | output | 1 | Generate of the whole 16-bit adder, with carry-in ignored |

## Verification
The bench targets carries that have to cross slice borders: all-ones operands plus a carry-in, sums that stop exactly at a slice edge such as `0x000F + 0x0001`, and top-bit overflow such as `0x8000 + 0x8000`. If a second-stage carry term were missing or wrong, the first bit of the next slice would be wrong and the sum would be off by a power of 16. The bench also checks cases where a slice only propagates and cases where it both propagates and generates. These separate OR-based propagate from XOR-based propagate in the exported flags. A slice generate that picked up the carry-in would show up in the cases where only `cin_i` differs.

// File: rtl/cla_pkg.sv
`timescale 1ns/1ps
// cla_pkg: default geometry shared by the adder, its checker and its bench.
// Assumes slice width and slice count are both at least 2.
package cla_pkg;
    parameter int unsigned CLA_GRP_W = 4;   // bits per lookahead slice
    parameter int unsigned CLA_N_GRP = 4;   // slices under the second stage
    parameter int unsigned CLA_W     = CLA_GRP_W * CLA_N_GRP;
endpackage

// File: rtl/cla_lookahead.sv
`timescale 1ns/1ps
// cla_lookahead: generic N-input lookahead unit.
// Takes N propagate/generate pairs and a carry-in. Returns the N-1 inner
// carries, each as a flat sum of products with no chained carry, and the
// unit-wide propagate/generate pair. Assumes N >= 2.
module cla_lookahead #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] p_i,
    input  logic [N-1:0] g_i,
    input  logic         ci_i,
    output logic [N-2:0] cy_o,
    output logic         up_o,
    output logic         ug_o
);
    logic acc;
    logic prod;
    logic gacc;

    // Expand every inner carry and the unit generate into products of p/g terms
    always_comb begin
        cy_o = '0;
        acc  = 1'b0;
        prod = 1'b0;
        gacc = 1'b0;
        for (int j = 1; j <= N; j++) begin
            acc = 1'b0;
            for (int i = 0; i < j; i++) begin
                prod = g_i[i];
                for (int k = i + 1; k < j; k++) prod = prod & p_i[k];
                acc = acc | prod;
            end
            if (j == N) gacc = acc;
            prod = ci_i;
            for (int k = 0; k < j; k++) prod = prod & p_i[k];
            acc = acc | prod;
            if (j < N) cy_o[j-1] = acc;
        end
        ug_o = gacc;
        up_o = &p_i;
    end
endmodule

// File: rtl/cla_group.sv
`timescale 1ns/1ps
// cla_group: one W-bit lookahead slice.
// Makes per-bit generate (AND) and propagate (OR) terms, gets its internal
// carries from a lookahead unit, and forms sum bits as a^b^carry.
// The carry into bit 0 comes from the second stage, never from a neighbour.
module cla_group #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         ci_i,
    output logic [W-1:0] s_o,
    output logic         gp_o,
    output logic         gg_o
);
    logic [W-1:0] bit_g;
    logic [W-1:0] bit_p;
    logic [W-2:0] inner_cy;
    logic [W-1:0] cvec;

    // Per-bit generate and propagate
    always_comb begin
        bit_g = a_i & b_i;
        bit_p = a_i | b_i;
    end

    cla_lookahead #(.N(W)) u_la (
        .p_i  (bit_p),
        .g_i  (bit_g),
        .ci_i (ci_i),
        .cy_o (inner_cy),
        .up_o (gp_o),
        .ug_o (gg_o)
    );

    // Sum bits from operands and the carry into each bit
    always_comb begin
        cvec = {inner_cy, ci_i};
        s_o  = a_i ^ b_i ^ cvec;
    end
endmodule

// File: rtl/cla2_adder.sv
`timescale 1ns/1ps
// cla2_adder: two-level carry-lookahead adder (default 4 x 4 = 16 bits).
// Slices report propagate/generate to a second lookahead stage, which gives
// every slice carry-in directly from those terms and cin. The carry-out is
// the block generate plus block propagate AND cin, the flat last term of the
// second stage. Purely combinational.
module cla2_adder
    import cla_pkg::*;
#(
    parameter int unsigned GRP_W = CLA_GRP_W,
    parameter int unsigned N_GRP = CLA_N_GRP
) (
    input  logic [GRP_W*N_GRP-1:0] a_i,
    input  logic [GRP_W*N_GRP-1:0] b_i,
    input  logic                   cin_i,
    output logic [GRP_W*N_GRP-1:0] sum_o,
    output logic                   cout_o,
    output logic [N_GRP-1:0]       grp_p_o,
    output logic [N_GRP-1:0]       grp_g_o,
    output logic                   blk_p_o,
    output logic                   blk_g_o
);
    logic [N_GRP-2:0] l2_cy;
    logic [N_GRP-1:0] gcin;

    // Carry into each slice: cin for slice 0, second-stage carries above
    always_comb gcin = {l2_cy, cin_i};

    for (genvar k = 0; k < N_GRP; k++) begin : g_slice
        cla_group #(.W(GRP_W)) u_grp (
            .a_i  (a_i[k*GRP_W +: GRP_W]),
            .b_i  (b_i[k*GRP_W +: GRP_W]),
            .ci_i (gcin[k]),
            .s_o  (sum_o[k*GRP_W +: GRP_W]),
            .gp_o (grp_p_o[k]),
            .gg_o (grp_g_o[k])
        );
    end

    cla_lookahead #(.N(N_GRP)) u_l2 (
        .p_i  (grp_p_o),
        .g_i  (grp_g_o),
        .ci_i (cin_i),
        .cy_o (l2_cy),
        .up_o (blk_p_o),
        .ug_o (blk_g_o)
    );

    // Final carry-out in flat form from the block pair and cin
    always_comb cout_o = blk_g_o | (blk_p_o & cin_i);
endmodule

// File: rtl/cla2_adder_chk.sv
`timescale 1ns/1ps
// cla2_adder_chk: port-level checker bound into cla2_adder.
// Compares every output with plain integer addition of the operands.
module cla2_adder_chk #(
    parameter int unsigned GRP_W = 4,
    parameter int unsigned N_GRP = 4
) (
    input logic [GRP_W*N_GRP-1:0] a_i,
    input logic [GRP_W*N_GRP-1:0] b_i,
    input logic                   cin_i,
    input logic [GRP_W*N_GRP-1:0] sum_o,
    input logic                   cout_o,
    input logic [N_GRP-1:0]       grp_p_o,
    input logic [N_GRP-1:0]       grp_g_o,
    input logic                   blk_p_o,
    input logic                   blk_g_o
);
    localparam int unsigned W = GRP_W * N_GRP;
    logic [W:0]     full_sum;
    logic [W:0]     raw_sum;
    logic [GRP_W:0] slice_sum;

    // Integer references for the whole word and each slice
    always_comb begin
        full_sum  = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
        raw_sum   = {1'b0, a_i} + {1'b0, b_i};
        slice_sum = '0;
        // R1
        sum_value_chk: assert (sum_o == full_sum[W-1:0])
            else $error("sum mismatch");
        // R2
        carry_out_chk: assert (cout_o == full_sum[W])
            else $error("carry-out mismatch");
        // R3
        blk_prop_chk: assert (blk_p_o == ((a_i | b_i) == {W{1'b1}}))
            else $error("block propagate mismatch");
        // R4
        blk_gen_chk: assert (blk_g_o == raw_sum[W])
            else $error("block generate mismatch");
        for (int k = 0; k < int'(N_GRP); k++) begin
            slice_sum = {1'b0, a_i[k*GRP_W +: GRP_W]} + {1'b0, b_i[k*GRP_W +: GRP_W]};
            // R5
            grp_prop_chk: assert (grp_p_o[k] == ((a_i[k*GRP_W +: GRP_W] | b_i[k*GRP_W +: GRP_W]) == {GRP_W{1'b1}}))
                else $error("slice propagate mismatch");
            // R6
            grp_gen_chk: assert (grp_g_o[k] == slice_sum[GRP_W])
                else $error("slice generate mismatch");
        end
    end
endmodule

bind cla2_adder cla2_adder_chk #(.GRP_W(GRP_W), .N_GRP(N_GRP)) u_chk (
    .a_i     (a_i),
    .b_i     (b_i),
    .cin_i   (cin_i),
    .sum_o   (sum_o),
    .cout_o  (cout_o),
    .grp_p_o (grp_p_o),
    .grp_g_o (grp_g_o),
    .blk_p_o (blk_p_o),
    .blk_g_o (blk_g_o)
);

// File: tb/cla2_adder_bench.sv
`timescale 1ns/1ps
// cla2_adder_bench: drives operands after each rising edge, compares all
// outputs with a behavioural integer model at the falling edge.
module cla2_adder_bench;
    import cla_pkg::*;
    localparam int W = CLA_W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a, b, sum;
    logic         cin, cout, bp, bg;
    logic [CLA_N_GRP-1:0] gp, gg;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    cla2_adder u_cla2_adder (
        .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout),
        .grp_p_o(gp), .grp_g_o(gg), .blk_p_o(bp), .blk_g_o(bg)
    );

    task automatic chk(string tag, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (a=%h b=%h cin=%b)", tag, act, exp, a, b, cin);
        end
    endtask

    // Apply one vector and compare every output with the integer model
    task automatic run(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv);
        longint tot, raw;
        @(posedge clk);
        #1;
        a = av; b = bv; cin = cv;
        @(negedge clk);
        tot = longint'(av) + longint'(bv) + longint'(cv);
        raw = longint'(av) + longint'(bv);
        chk("R1 sum", sum, tot % (64'd1 << W));
        chk("R2 cout", cout, (tot >> W) & 1);
        chk("R3 blk_p", bp, ((av | bv) == {W{1'b1}}));
        chk("R4 blk_g", bg, (raw >> W) & 1);
        for (int k = 0; k < CLA_N_GRP; k++) begin
            longint sa, sb;
            sa = (longint'(av) >> (k*CLA_GRP_W)) & ((1 << CLA_GRP_W) - 1);
            sb = (longint'(bv) >> (k*CLA_GRP_W)) & ((1 << CLA_GRP_W) - 1);
            chk("R5 grp_p", gp[k], ((sa | sb) == ((1 << CLA_GRP_W) - 1)));
            chk("R6 grp_g", gg[k], ((sa + sb) >> CLA_GRP_W) & 1);
        end
    endtask

    initial begin
        a = '0; b = '0; cin = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R8: all-zero inputs give all-zero outputs
        @(negedge clk);
        chk("R8 zero sum", sum, 0);
        chk("R8 zero cout", cout, 0);
        chk("R8 zero flags", {gp, gg, bp, bg}, 0);
        // R7: carry crossing all slices
        run(16'hFFFF, 16'h0000, 1'b1);
        chk("R7 ripple sum", sum, 0);
        chk("R7 ripple cout", cout, 1);
        run(16'hFFFF, 16'hFFFF, 1'b1);
        run(16'hFFFF, 16'hFFFF, 1'b0);
        run(16'h8000, 16'h8000, 1'b0);
        run(16'h000F, 16'h0001, 1'b0);
        run(16'h00FF, 16'h0001, 1'b0);
        run(16'h0FFF, 16'h0000, 1'b1);
        run(16'hAAAA, 16'h5555, 1'b0);
        run(16'hAAAA, 16'h5555, 1'b1);
        run(16'hF0F0, 16'h0F0F, 1'b1);
        run(16'h1111, 16'hFFFF, 1'b0);
        run(16'h7FFF, 16'h0001, 1'b0);
        for (int i = 0; i < 3000; i++)
            run(W'($urandom), W'($urandom), 1'($urandom));
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        #(20 * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule